// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer with Distributed Refresh

This block turns single-word requests on a plain synchronous port (valid/ready handshake, full-width address, write enable, write data) into strobed accesses on a DRAM-style pin interface. The pin address bus is half as wide as the request address. Each access sends the low half first as a row address, with the row strobe (`dram_ras_n`) pulled low. It then sends the high half as a column address, with the column strobe (`dram_cas_n`) pulled low. An attached memory array latches the row on the falling edge of the row strobe and the column on the falling edge of the column strobe.

The block keeps row contents alive by distributed refresh. A timer raises a refresh request every `REF_INTERVAL` clock cycles. The sequencer serves that request between normal accesses as a row-only cycle, so there is never a long blackout window. A refresh row counter is as wide as the row address. A 2-to-1 selector places either that counter or the request's row on the row path. Read and write sequences have the same shape and length, so every access cycle measures the same from one row-strobe fall to the next.

The sequencer states are:
- `ST_IDLE`: ready, or about to start a refresh.
- `ST_ACT`: row strobe low, row address on the bus.
- `ST_COL`: column strobe low, column address on the bus, write enable driven.
- `ST_HOLD`: both strobes held low while read data settles and is sampled.
- `ST_PRE`: both strobes high; read result strobed out.
- `ST_REF_ACT` and `ST_REF_HOLD`: row strobe low with the refresh row on the bus.
- `ST_REF_PRE`: strobes high.

The transitions are:
- `ST_IDLE` to `ST_REF_ACT` when a refresh is due; this takes priority.
- `ST_IDLE` to `ST_ACT` on an accepted request.
- `ST_ACT` to `ST_COL` to `ST_HOLD` to `ST_PRE` to `ST_IDLE`, unconditionally.
- `ST_REF_ACT` to `ST_REF_HOLD` to `ST_REF_PRE` to `ST_IDLE`, unconditionally.

Top module: `dram_ras_cas_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `rd_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle `dram_ras_n` is 0 and `dram_cas_n` is 1, with `dram_addr` equal to request address bits [ROW_W-1:0]. In the cycle after that, `dram_cas_n` is 0 with `dram_addr` equal to bits [2*ROW_W-1:ROW_W]. The column strobe is never low while the row strobe is high.
- R3: For a write, `dram_we_n` is 0 and `dram_wdata` carries the request data while `dram_cas_n` is low. `dram_we_n` is 1 at all other times, and 1 during reads. Data written this way is returned by a later read of the same address.
- R4: For a read, `rd_valid` is 1 for exactly one cycle, the fourth cycle after acceptance (the cycle in which `dram_cas_n` returns high). `rd_data` then holds the word that the array presented while the column strobe was low.
- R5: Every access, read or write, holds `dram_ras_n` low for exactly 3 cycles, of which `dram_cas_n` is low for the last 2. An access in progress is never cut short by a refresh coming due.
- R6: A refresh is a row-only cycle: `dram_ras_n` low for exactly 2 cycles, `dram_cas_n` high throughout, and `dram_addr` equal to the refresh row counter.
- R7: The refresh row starts at 0 after reset and increases by 1 after each refresh. It wraps from 2^ROW_W-1 back to 0.
- R8: With no requests offered, row-only cycles start exactly `REF_INTERVAL` cycles apart.
- R9: When a refresh is due, `req_ready` is 0 and the refresh starts before any waiting request is accepted.
- R10: `req_ready` is 0 in every cycle of an access or refresh sequence. While `req_ready` is 1, both strobes are high.
- R11: `rd_valid` stays 0 for write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ROW_W | Word address; low half is row, high half is column |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle strobe marking valid read data |
| rd_data | output | DATA_W | Read result |
| dram_addr | output | ROW_W | Multiplexed row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | DATA_W | Data to the array |
| dram_rdata | input | DATA_W | Data from the array |

## Verification
The assertions check the pin ordering on every cycle:
- the column strobe only inside a row-strobe window;
- write enable only inside the column phase;
- the row strobe falling one cycle after each accepted handshake;
- single-cycle read strobes that coincide with the column strobe rising;
- the handshake closed whenever a refresh is due.

Only the bench's scenarios can show the rest:
- which address half appears in which phase;
- that stored words come back intact;
- the exact 3-cycle and 2-cycle strobe windows;
- the refresh row sequence through its wrap, and the exact refresh spacing on an idle port;
- a waiting request yielding to a due refresh.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_HOLD,
        ST_PRE,
        ST_REF_ACT,
        ST_REF_HOLD,
        ST_REF_PRE
    } dsc_state_e;

    typedef enum logic {
        ADDR_ROW,
        ADDR_COL
    } addr_phase_e;

endpackage

// File: rtl/dsc_refresh_timer.sv
module dsc_refresh_timer #(
    parameter int REF_INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic due
);
    localparam int CW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

    logic [CW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            due <= 1'b0;
        end else if (tick) begin
            due <= 1'b1;
        end else if (grant) begin
            due <= 1'b0;
        end
    end

endmodule

// File: rtl/dsc_row_source.sv
module dsc_row_source #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             pick_refresh,
    input  logic [ROW_W-1:0] req_row,
    output logic [ROW_W-1:0] row_out
);
    logic [ROW_W-1:0] ref_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_row <= '0;
        end else if (advance) begin
            ref_row <= ref_row + 1'b1;
        end
    end

    assign row_out = pick_refresh ? ref_row : req_row;

endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
    import dsc_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [2*ROW_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    input  logic                ref_due,
    output logic                ref_start,
    output logic                ref_done,
    output logic                pick_refresh,
    output addr_phase_e         addr_phase,
    output logic [ROW_W-1:0]    lat_row,
    output logic [ROW_W-1:0]    lat_col,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   rdata,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);
    dsc_state_e state, state_nx;
    logic       lat_we;
    logic       accept;

    assign accept = (state == ST_IDLE) && !ref_due && req_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_due) begin
                    state_nx = ST_REF_ACT;
                end else if (req_valid) begin
                    state_nx = ST_ACT;
                end
            end
            ST_ACT:      state_nx = ST_COL;
            ST_COL:      state_nx = ST_HOLD;
            ST_HOLD:     state_nx = ST_PRE;
            ST_PRE:      state_nx = ST_IDLE;
            ST_REF_ACT:  state_nx = ST_REF_HOLD;
            ST_REF_HOLD: state_nx = ST_REF_PRE;
            ST_REF_PRE:  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_row <= '0;
            lat_col <= '0;
            lat_we  <= 1'b0;
            wdata   <= '0;
        end else if (accept) begin
            lat_row <= req_addr[ROW_W-1:0];
            lat_col <= req_addr[2*ROW_W-1:ROW_W];
            lat_we  <= req_we;
            wdata   <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if ((state == ST_HOLD) && !lat_we) begin
            rd_data <= rdata;
        end
    end

    always_comb begin
        ras_n        = 1'b1;
        cas_n        = 1'b1;
        we_n         = 1'b1;
        addr_phase   = ADDR_ROW;
        pick_refresh = 1'b0;
        req_ready    = 1'b0;
        ref_start    = 1'b0;
        ref_done     = 1'b0;
        rd_valid     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = !ref_due;
                ref_start = ref_due;
            end
            ST_ACT: begin
                ras_n = 1'b0;
            end
            ST_COL, ST_HOLD: begin
                ras_n      = 1'b0;
                cas_n      = 1'b0;
                we_n       = !lat_we;
                addr_phase = ADDR_COL;
            end
            ST_PRE: begin
                rd_valid = !lat_we;
            end
            ST_REF_ACT: begin
                ras_n        = 1'b0;
                pick_refresh = 1'b1;
            end
            ST_REF_HOLD: begin
                ras_n        = 1'b0;
                pick_refresh = 1'b1;
                ref_done     = 1'b1;
            end
            ST_REF_PRE: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dram_ras_cas_ctrl.sv
module dram_ras_cas_ctrl
    import dsc_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int DATA_W       = 16,
    parameter int REF_INTERVAL = 780
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_we,
    input  logic [2*ROW_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ROW_W-1:0]    dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic [DATA_W-1:0]   dram_wdata,
    input  logic [DATA_W-1:0]   dram_rdata
);
    logic             ref_due;
    logic             ref_start;
    logic             ref_done;
    logic             pick_refresh;
    addr_phase_e      addr_phase;
    logic [ROW_W-1:0] lat_row;
    logic [ROW_W-1:0] lat_col;
    logic [ROW_W-1:0] row_path;

    dsc_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .grant (ref_start),
        .due   (ref_due)
    );

    dsc_row_source #(.ROW_W(ROW_W)) u_rows (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance      (ref_done),
        .pick_refresh (pick_refresh),
        .req_row      (lat_row),
        .row_out      (row_path)
    );

    dsc_fsm #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .ref_due      (ref_due),
        .ref_start    (ref_start),
        .ref_done     (ref_done),
        .pick_refresh (pick_refresh),
        .addr_phase   (addr_phase),
        .lat_row      (lat_row),
        .lat_col      (lat_col),
        .ras_n        (dram_ras_n),
        .cas_n        (dram_cas_n),
        .we_n         (dram_we_n),
        .wdata        (dram_wdata),
        .rdata        (dram_rdata),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

    assign dram_addr = (addr_phase == ADDR_COL) ? lat_col : row_path;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic ref_due
);
    // R2
    cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R2
    ras_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> $fell(dram_ras_n));

    // R3
    we_in_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> !dram_cas_n);

    // R4
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R4
    rd_at_cas_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(dram_cas_n));

    // R9
    due_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_due |-> !req_ready);

    // R10
    ready_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_n && dram_cas_n));

endmodule

bind dram_ras_cas_ctrl dsc_checker u_dsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .ref_due    (ref_due)
);

// File: tb/test_dram_ras_cas_ctrl.sv
module test_dram_ras_cas_ctrl;
    localparam int ROW_W    = 10;
    localparam int DATA_W   = 16;
    localparam int INTERVAL = 37;
    localparam int AW       = 2 * ROW_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [ROW_W-1:0]  dram_addr;
    logic              dram_ras_n;
    logic              dram_cas_n;
    logic              dram_we_n;
    logic [DATA_W-1:0] dram_wdata;
    logic [DATA_W-1:0] dram_rdata = '0;

    always #5 clk = ~clk;

    dram_ras_cas_ctrl #(.ROW_W(ROW_W), .DATA_W(DATA_W), .REF_INTERVAL(INTERVAL)) i_dram_ras_cas_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .dram_addr  (dram_addr),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_we_n  (dram_we_n),
        .dram_wdata (dram_wdata),
        .dram_rdata (dram_rdata)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Array model and strobe monitor
    logic [DATA_W-1:0] mem [logic [AW-1:0]];
    logic              prev_ras = 1'b1;
    logic              prev_cas = 1'b1;
    int                ras_len = 0;
    int                ras_start = 0;
    logic [ROW_W-1:0]  ras_addr = '0;
    bit                saw_cas = 0;
    logic [ROW_W-1:0]  exp_row = '0;
    int                ref_cnt = 0;
    bit                wrap_seen = 0;
    bit                interval_chk = 0;
    bit                last_ref_valid = 0;
    int                last_ref_start = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!dram_ras_n && prev_ras) begin
                ras_len   = 1;
                ras_addr  = dram_addr;
                saw_cas   = 0;
                ras_start = cyc;
            end else if (!dram_ras_n) begin
                ras_len++;
            end
            if (!dram_cas_n && prev_cas) begin
                if (!dram_we_n) begin
                    mem[{dram_addr, ras_addr}] = dram_wdata;
                end else begin
                    dram_rdata = mem.exists({dram_addr, ras_addr}) ? mem[{dram_addr, ras_addr}] : '0;
                end
            end
            if (!dram_cas_n) saw_cas = 1;
            if (dram_ras_n && !prev_ras) begin
                if (!saw_cas) begin
                    check(ras_len == 2, "R6", "refresh row-strobe length", ras_len, 2);
                    check(ras_addr == exp_row, "R7", "refresh row", ras_addr, exp_row);
                    if (ras_addr == '0 && ref_cnt > 0) wrap_seen = 1;
                    if (interval_chk && last_ref_valid)
                        check(ras_start - last_ref_start == INTERVAL, "R8", "refresh spacing",
                              ras_start - last_ref_start, INTERVAL);
                    last_ref_start = ras_start;
                    last_ref_valid = 1;
                    exp_row = exp_row + 1'b1;
                    ref_cnt++;
                end else begin
                    check(ras_len == 3, "R5", "access row-strobe length", ras_len, 3);
                end
            end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    // Caller is at a negedge; returns at a negedge with the bus idle
    task automatic do_access(input logic we, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!dram_ras_n && dram_cas_n, "R2", "row phase strobes", {dram_ras_n, dram_cas_n}, 2'b01);
        check(dram_addr == a[ROW_W-1:0], "R2", "row address", dram_addr, a[ROW_W-1:0]);
        check(!req_ready, "R10", "ready in row phase", req_ready, 0);
        @(negedge clk);
        check(!dram_cas_n, "R2", "column strobe", dram_cas_n, 0);
        check(dram_addr == a[AW-1:ROW_W], "R2", "column address", dram_addr, a[AW-1:ROW_W]);
        check(dram_we_n == !we, "R3", "write enable", dram_we_n, !we);
        if (we) check(dram_wdata == d, "R3", "write data", dram_wdata, d);
        check(!req_ready, "R10", "ready in column phase", req_ready, 0);
        @(negedge clk);
        check(!dram_cas_n && !dram_ras_n, "R5", "hold phase strobes", {dram_ras_n, dram_cas_n}, 0);
        @(negedge clk);
        if (we) begin
            check(!rd_valid, "R11", "no read strobe on write", rd_valid, 0);
        end else begin
            check(rd_valid, "R4", "read strobe", rd_valid, 1);
            check(rd_data == d, "R4", "read data", rd_data, d);
        end
        check(!req_ready, "R10", "ready in close phase", req_ready, 0);
        @(negedge clk);
        check(!rd_valid, "R4", "read strobe one cycle", rd_valid, 0);
    endtask

    typedef struct packed {
        logic              we;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] data;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 20'h00000, 16'h1111},
        '{1'b1, 20'hFFFFF, 16'h2222},
        '{1'b1, 20'h003FF, 16'h3333},
        '{1'b1, 20'hFFC00, 16'h4444},
        '{1'b1, 20'h5A5A5, 16'hBEEF},
        '{1'b0, 20'h00000, 16'h1111},
        '{1'b0, 20'hFFFFF, 16'h2222},
        '{1'b0, 20'h003FF, 16'h3333},
        '{1'b0, 20'hFFC00, 16'h4444},
        '{1'b0, 20'h5A5A5, 16'hBEEF},
        '{1'b1, 20'h5A5A5, 16'h0F0F},
        '{1'b0, 20'h5A5A5, 16'h0F0F}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic prev_rdy;
        repeat (3) @(negedge clk);
        check(req_ready && dram_ras_n && dram_cas_n && dram_we_n && !rd_valid, "R1",
              "outputs in reset", {req_ready, dram_ras_n, dram_cas_n, dram_we_n, rd_valid}, 5'b11110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && dram_ras_n && dram_cas_n && dram_we_n && !rd_valid, "R1",
              "outputs after reset", {req_ready, dram_ras_n, dram_cas_n, dram_we_n, rd_valid}, 5'b11110);

        for (int i = 0; i < 12; i++) begin
            do_access(VECS[i].we, VECS[i].addr, VECS[i].data);
        end

        // R9: refresh due while a request waits
        prev_rdy = req_ready;
        @(negedge clk);
        while (!(prev_rdy && !req_ready)) begin
            prev_rdy = req_ready;
            @(negedge clk);
        end
        req_valid = 1'b1;
        req_we    = 1'b0;
        req_addr  = 20'hFFFFF;
        @(negedge clk);
        check(!dram_ras_n && dram_cas_n, "R9", "refresh before waiting request",
              {dram_ras_n, dram_cas_n}, 2'b01);
        check(!req_ready, "R9", "ready while refresh runs", req_ready, 0);
        do_access(1'b0, 20'hFFFFF, 16'h2222);

        // R8 and R7: idle port, run through a full row wrap
        repeat (2 * INTERVAL) @(negedge clk);
        interval_chk = 1;
        repeat (1100 * INTERVAL) @(negedge clk);
        interval_chk = 0;
        check(wrap_seen, "R7", "refresh row wrapped to zero", wrap_seen, 1);
        check(ref_cnt >= 1024, "R7", "refresh count", ref_cnt, 1024);

        // R3: contents survive refresh traffic
        do_access(1'b0, 20'h003FF, 16'h3333);
        do_access(1'b0, 20'h5A5A5, 16'h0F0F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule